// File: doc/BRIEF.md
# Exception Entry and Exit Sequencer

This block sets the timing of exception handling in a processor core. An arbiter upstream picks the most urgent pending exception and raises a preempt request when that exception may interrupt what is running now. The sequencer accepts the request and counts out a fixed entry latency before the handler starts. When a handler signals that it is done, the sequencer either returns to the interrupted context after a fixed return latency or goes straight to the next pending exception on a shorter chained path.

While entry or a chained start is under way, a more urgent exception that arrives late takes over the slot that is being prepared. It starts at the time already set and no work is done twice. The exception that was displaced stays pending in the arbiter and is chained in later. The sequencer keeps a stack of the numbers of preempted handlers. On each return it restores the number on top of that stack. It reports the running exception number, whether the running handler has interrupted another one, and strobes that tell the register bank which exception became active and which one completed.

Top module: `exc_entry_seq`

## Requirements
- R1: When a request is accepted (preempt request high with a non-zero selected number while a handler or thread code runs), the handler start strobe appears exactly 12 clock cycles after the accepting edge. The active number keeps its previous value during those cycles.
- R2: A done pulse with nothing pending starts a return. 12 cycles after the edge that samples the done pulse, the active number becomes the top of the nesting stack, or 0 if the stack is empty.
- R3: A done pulse that arrives together with a preempt request starts the selected exception 6 cycles after the sampling edge. There is no return in between.
- R4: A preempt request during entry or a chained start, for a number different from the one being prepared, switches the target without restarting the countdown. Only the new number is started, at the time already set.
- R5: After a handler that took over by late arrival finishes, the exception it displaced is chained in on the 6-cycle path when it is still requested.
- R6: A preempt request that is sampled during a return turns the return into a chained start that finishes 6 cycles after that edge. The active number is held until that start.
- R7: The active number is 0 in thread mode and is the number of the running handler otherwise.
- R8: The return-to-base flag is 1 when the nesting stack is empty and 0 while the running handler has preempted another one.
- R9: The nesting stack is last-in first-out and DEPTH entries deep. A push onto a full stack is dropped and sets a sticky overflow flag that only reset clears.
- R10: The activation strobe and the handler start pulse are high for one cycle at handler start and carry the started number. The completion strobe is high for one cycle, on the edge that samples done, and carries the finishing number. A done pulse in thread mode produces no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_num | input | NUM_W | Exception number chosen by the arbiter, 0 for none |
| preempt_req | input | 1 | The selected exception may preempt the current context |
| hdl_done | input | 1 | Pulse: the running handler has finished |
| active_num | output | NUM_W | Number of the running handler, 0 in thread mode |
| ret_to_base | output | 1 | No other handler is stacked under the running one |
| act_stb | output | 1 | Activation strobe to the register bank |
| act_num | output | NUM_W | Number that was activated |
| cmp_stb | output | 1 | Completion strobe to the register bank |
| cmp_num | output | NUM_W | Number that completed |
| hdl_start | output | 1 | Pulse: handler execution begins |
| nest_ovf | output | 1 | Sticky nesting stack overflow |

## Verification
A countdown that is loaded with the wrong value moves the handler start away from the expected cycle by one or more cycles, and the scoreboard matches every start and completion to its exact cycle. A stack that is wrong, or a target that is not switched, does not show at first. It appears as a wrong active number on the next return, or as the wrong number on the next start strobe, at most 12 cycles later. To expose these faults the bench nests five levels deep and runs late-arrival and chained sequences.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_ENTRY  = 2'd1,
    ST_TAIL   = 2'd2,
    ST_RETURN = 2'd3
  } seq_state_t;

  // countdown value loaded so that the action lands 'cycles' edges later
  function automatic int unsigned cd_load(input int unsigned cycles);
    return cycles - 1;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/exc_seq_timer.sv
module exc_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] cnt,
  output logic          expired
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (cnt != '0)       cnt <= cnt - CW'(1);
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/exc_seq_stack.sv
module exc_seq_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] top,
  output logic         empty,
  output logic         ovf
);

  localparam int SPW = $clog2(DEPTH + 1);

  logic [SPW-1:0] sp;
  logic [W-1:0]   slot [DEPTH];
  logic           full;

  assign full  = (sp == SPW'(DEPTH));
  assign empty = (sp == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          slot[g] <= '0;
      else if (push && sp == SPW'(g))      slot[g] <= din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp  <= '0;
      ovf <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      sp  <= sp + SPW'(1);
    end else if (pop && !empty) begin
      sp <= sp - SPW'(1);
    end
  end

  always_comb begin
    top = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp == SPW'(i + 1)) top = slot[i];
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  // R9
  no_grow_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> full && ovf);

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int NUM_W      = 9,
  parameter int DEPTH      = 4,
  parameter int ENTRY_CYC  = 12,
  parameter int RETURN_CYC = 12,
  parameter int TAIL_CYC   = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_W-1:0] sel_num,
  input  logic             preempt_req,
  input  logic             hdl_done,
  output logic [NUM_W-1:0] active_num,
  output logic             ret_to_base,
  output logic             act_stb,
  output logic [NUM_W-1:0] act_num,
  output logic             cmp_stb,
  output logic [NUM_W-1:0] cmp_num,
  output logic             hdl_start,
  output logic             nest_ovf
);

  localparam int unsigned MAXC = max3(ENTRY_CYC, RETURN_CYC, TAIL_CYC);
  localparam int CW = (MAXC > 2) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] LD_ENTRY  = CW'(cd_load(ENTRY_CYC));
  localparam logic [CW-1:0] LD_RETURN = CW'(cd_load(RETURN_CYC));
  localparam logic [CW-1:0] LD_TAIL   = CW'(cd_load(TAIL_CYC));

  seq_state_t       state_q;
  logic [NUM_W-1:0] active_q;
  logic [NUM_W-1:0] target_q;

  // named internal events
  logic             want_req;
  logic             counting;
  logic             accept_ev;
  logic             done_ev;
  logic             late_ev;
  logic             chain_ev;
  logic             start_ev;
  logic             back_ev;
  logic [NUM_W-1:0] start_num;

  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic [CW-1:0]    tmr_cnt;
  logic             tmr_exp;

  logic             stk_push;
  logic             stk_pop;
  logic [NUM_W-1:0] stk_top;
  logic             stk_empty;

  always_comb begin
    want_req  = preempt_req && (sel_num != '0);
    counting  = (state_q == ST_ENTRY) || (state_q == ST_TAIL);
    done_ev   = (state_q == ST_RUN) && hdl_done && (active_q != '0);
    accept_ev = (state_q == ST_RUN) && !done_ev && want_req;
    late_ev   = counting && want_req && (sel_num != target_q);
    chain_ev  = (state_q == ST_RETURN) && want_req;
    start_ev  = counting && tmr_exp;
    back_ev   = (state_q == ST_RETURN) && tmr_exp && !chain_ev;
    start_num = late_ev ? sel_num : target_q;
  end

  always_comb begin
    tmr_load = accept_ev || done_ev || chain_ev;
    if (accept_ev)                       tmr_val = LD_ENTRY;
    else if (chain_ev || (done_ev && want_req)) tmr_val = LD_TAIL;
    else                                 tmr_val = LD_RETURN;
  end

  assign stk_push = accept_ev && (active_q != '0);
  assign stk_pop  = back_ev;

  exc_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .cnt      (tmr_cnt),
    .expired  (tmr_exp)
  );

  exc_seq_stack #(.DEPTH(DEPTH), .W(NUM_W)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (stk_push),
    .pop   (stk_pop),
    .din   (active_q),
    .top   (stk_top),
    .empty (stk_empty),
    .ovf   (nest_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RUN;
      active_q <= '0;
      target_q <= '0;
      act_stb  <= 1'b0;
      act_num  <= '0;
      cmp_stb  <= 1'b0;
      cmp_num  <= '0;
    end else begin
      act_stb <= start_ev;
      cmp_stb <= done_ev;
      if (done_ev) cmp_num <= active_q;
      unique case (state_q)
        ST_RUN: begin
          if (done_ev) begin
            state_q  <= want_req ? ST_TAIL : ST_RETURN;
            target_q <= sel_num;
          end else if (accept_ev) begin
            state_q  <= ST_ENTRY;
            target_q <= sel_num;
          end
        end
        ST_ENTRY, ST_TAIL: begin
          if (start_ev) begin
            state_q  <= ST_RUN;
            active_q <= start_num;
            act_num  <= start_num;
          end else if (late_ev) begin
            target_q <= sel_num;
          end
        end
        ST_RETURN: begin
          if (chain_ev) begin
            state_q  <= ST_TAIL;
            target_q <= sel_num;
          end else if (back_ev) begin
            state_q  <= ST_RUN;
            active_q <= stk_top;
          end
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end

  assign active_num  = active_q;
  assign ret_to_base = stk_empty;
  assign hdl_start   = act_stb;

  // R1
  entry_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (state_q == ST_ENTRY) && (tmr_cnt == LD_ENTRY));

  // R4
  late_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (late_ev && !tmr_exp) |=> (tmr_cnt == $past(tmr_cnt) - CW'(1)));

  // R10
  act_matches_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_stb |-> (active_num == act_num) && (act_num != '0));

  // R10
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_stb, cmp_stb}));

  // R2
  active_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && !tmr_exp) |=> $stable(active_num));

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

  localparam int NUM_W = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NUM_W-1:0] sel_num = '0;
  logic             preempt_req = 1'b0;
  logic             hdl_done = 1'b0;
  logic [NUM_W-1:0] active_num;
  logic             ret_to_base;
  logic             act_stb;
  logic [NUM_W-1:0] act_num;
  logic             cmp_stb;
  logic [NUM_W-1:0] cmp_num;
  logic             hdl_start;
  logic             nest_ovf;

  always #4 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sel_num(sel_num), .preempt_req(preempt_req),
    .hdl_done(hdl_done), .active_num(active_num), .ret_to_base(ret_to_base),
    .act_stb(act_stb), .act_num(act_num), .cmp_stb(cmp_stb), .cmp_num(cmp_num),
    .hdl_start(hdl_start), .nest_ovf(nest_ovf)
  );

  int pcyc = 0;
  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always @(posedge clk) pcyc <= pcyc + 1;

  typedef struct {
    bit    is_start;
    int    num;
    int    cyc;
    string req;
  } ev_t;

  ev_t exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, pcyc);
    end
  endtask

  task automatic push_exp(input bit st, input int num, input int cyc, input string req);
    ev_t e;
    e.is_start = st; e.num = num; e.cyc = cyc; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic mon_event(input bit st, input int num);
    ev_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, st ? "R10 unexpected start" : "R10 unexpected completion", num, 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.is_start == st, {e.req, " event kind"}, int'(st), int'(e.is_start));
      chk(e.num == num, {e.req, " event number"}, num, e.num);
      chk(e.cyc == pcyc, {e.req, " event cycle"}, pcyc, e.cyc);
    end
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (hdl_start) begin
        mon_event(1'b1, int'(act_num));
        chk(act_stb && active_num == act_num, "R10 start strobes agree",
            int'(active_num), int'(act_num));
      end
      if (cmp_stb) mon_event(1'b0, int'(cmp_num));
    end
  end

  task automatic go_to(input int c);
    while (pcyc < c) @(negedge clk);
  endtask

  task automatic pulse_req(input int n);
    sel_num = NUM_W'(n);
    preempt_req = 1'b1;
    @(negedge clk);
    preempt_req = 1'b0;
  endtask

  task automatic pulse_done(input bit with_req, input int n);
    if (with_req) begin
      sel_num = NUM_W'(n);
      preempt_req = 1'b1;
    end
    hdl_done = 1'b1;
    @(negedge clk);
    hdl_done = 1'b0;
    preempt_req = 1'b0;
  endtask

  task automatic enter(input int n);
    int p;
    p = pcyc;
    push_exp(1'b1, n, p + 12 + 1, "R1");
    pulse_req(n);
    go_to(p + 12);
    chk(active_num != NUM_W'(n), "R1 not started before 12 cycles", int'(active_num), -1);
    go_to(p + 13);
    chk(active_num == NUM_W'(n), "R7 active after entry", int'(active_num), n);
  endtask

  task automatic leave(input int n, input int after);
    int q;
    q = pcyc;
    push_exp(1'b0, n, q + 1, "R10");
    pulse_done(1'b0, 0);
    go_to(q + 12);
    chk(active_num == NUM_W'(n), "R2 held during return", int'(active_num), n);
    go_to(q + 13);
    chk(active_num == NUM_W'(after), "R2 restored after return", int'(active_num), after);
  endtask

  initial begin
    int p;
    int q;
    repeat (3) @(negedge clk);
    chk(active_num == '0, "R7 reset active", int'(active_num), 0);
    chk(ret_to_base == 1'b1, "R8 reset flag", int'(ret_to_base), 1);
    chk(!act_stb && !cmp_stb && !hdl_start, "R10 reset strobes",
        int'({act_stb, cmp_stb, hdl_start}), 0);
    chk(!nest_ovf, "R9 reset overflow", int'(nest_ovf), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // plain entry and return
    enter(20);
    chk(ret_to_base == 1'b1, "R8 single handler", int'(ret_to_base), 1);
    leave(20, 0);

    // preemption nesting
    enter(20);
    p = pcyc;
    push_exp(1'b1, 17, p + 13, "R1");
    pulse_req(17);
    go_to(p + 6);
    chk(active_num == 9'd20, "R1 active held during entry", int'(active_num), 20);
    go_to(p + 13);
    chk(active_num == 9'd17, "R7 preempting handler", int'(active_num), 17);
    chk(ret_to_base == 1'b0, "R8 nested flag", int'(ret_to_base), 0);
    leave(17, 20);
    chk(ret_to_base == 1'b1, "R8 back to single", int'(ret_to_base), 1);
    leave(20, 0);

    // tail chain at done
    enter(30);
    q = pcyc;
    push_exp(1'b0, 30, q + 1, "R3");
    push_exp(1'b1, 31, q + 7, "R3");
    pulse_done(1'b1, 31);
    go_to(q + 7);
    chk(active_num == 9'd31, "R3 chained handler", int'(active_num), 31);
    leave(31, 0);

    // late arrival then chain back to the displaced one
    p = pcyc;
    push_exp(1'b1, 25, p + 13, "R4");
    pulse_req(40);
    go_to(p + 5);
    pulse_req(25);
    go_to(p + 13);
    chk(active_num == 9'd25, "R4 late arrival started", int'(active_num), 25);
    q = pcyc;
    push_exp(1'b0, 25, q + 1, "R5");
    push_exp(1'b1, 40, q + 7, "R5");
    pulse_done(1'b1, 40);
    go_to(q + 7);
    chk(active_num == 9'd40, "R5 displaced one chained", int'(active_num), 40);
    leave(40, 0);

    // return turned into a chain
    enter(50);
    q = pcyc;
    push_exp(1'b0, 50, q + 1, "R6");
    push_exp(1'b1, 51, q + 11, "R6");
    pulse_done(1'b0, 0);
    go_to(q + 4);
    pulse_req(51);
    go_to(q + 10);
    chk(active_num == 9'd50, "R6 held before chain", int'(active_num), 50);
    go_to(q + 11);
    chk(active_num == 9'd51, "R6 chained from return", int'(active_num), 51);
    leave(51, 0);

    // done in thread mode is ignored
    pulse_done(1'b0, 0);
    repeat (3) @(negedge clk);
    chk(active_num == '0, "R10 thread done ignored", int'(active_num), 0);
    chk(exp_q.size() == 0, "R10 no stray events", exp_q.size(), 0);

    // nesting beyond stack depth
    for (int k = 60; k <= 64; k++) enter(k);
    chk(!nest_ovf, "R9 full stack no overflow", int'(nest_ovf), 0);
    enter(65);
    chk(nest_ovf, "R9 overflow set", int'(nest_ovf), 1);
    chk(ret_to_base == 1'b0, "R8 deep nesting", int'(ret_to_base), 0);
    leave(65, 63);
    leave(63, 62);
    leave(62, 61);
    leave(61, 60);
    chk(ret_to_base == 1'b1, "R8 stack drained", int'(ret_to_base), 1);
    leave(60, 0);
    chk(nest_ovf, "R9 overflow sticky", int'(nest_ovf), 1);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all events seen", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", pcyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule